// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns the system clock into the serial clock of an SPI master and tells the neighbouring shift register when to act. A 5-bit divide code picks the serial clock rate. The code space is split in two. When the top bit is clear, the low four bits give the divisor directly. When the top bit is set, the divisor is twice the low four bits. This reaches even divisors up to 30 without a wider field.

Polarity and phase inputs set the idle level of the serial clock and choose which edge captures data. A late-capture input moves the capture strobe to the following edge, for use at the fastest rates. The transfer engine raises busy for as long as it wants clocks. While busy is low, the serial clock rests at its idle level and no strobes are produced.

Each serial clock edge comes with two registered single-cycle strobes, appearing in the same system cycle as the edge. The launch strobe tells the shift register to drive the next bit. The sample strobe tells it to capture the incoming bit.

Top module: `spi_sclk_gen`

## Requirements
- R1: While busy is low (and out of reset), sclk equals cpol and both launch and sample are low.
- R2: With code bit 4 clear and a code from 2 to 15, the serial clock period is that many system cycles.
- R3: With code bit 4 set, the divisor is twice the value of code bits 3:0. Codes 0x18 to 0x1F give 16 to 30. A result below 2 is raised to 2.
- R4: Codes 0 and 1 both give a divisor of 2, the fastest rate the block makes.
- R5: Within each period of divisor D, sclk stays at the non-idle level for ceil(D/2) cycles and at the idle level for floor(D/2) cycles. For odd D, the non-idle phase is one cycle longer.
- R6: The first sclk edge of a transfer appears right after the floor(D/2)-th rising system clock edge at which busy is high, counting the first such edge as 1.
- R7: The leading edge is the move away from the idle level. With cpha 0, sample pulses on leading edges and launch on trailing edges. With cpha 1 it is the reverse. Each strobe is high for exactly one cycle, in the cycle in which sclk shows the new level.
- R8: With late_capture high, sample moves to the other edge type (trailing for cpha 0, leading for cpha 1). The launch strobe does not move.
- R9: When busy is sampled low, sclk returns to cpol at that edge and no strobe is produced. The next transfer restarts its timing from the start of a half-period, as in R6.
- R10: sclk is cpol while the internal phase is idle, and the inverse of cpol during the non-idle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_code | input | 5 | Divide code. Bit 4 selects the doubled range. |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| late_capture | input | 1 | Moves the sample strobe one edge later |
| busy | input | 1 | High while the transfer engine wants serial clocks |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe: drive the next output bit |
| sample | output | 1 | One-cycle strobe: capture the input bit |

## Verification
The assertions assume that prescale_code, cpol, cpha and late_capture stay steady while busy is high. The edge-type checks on launch and sample compare sclk against the current cpol, so a mid-transfer change would break them. The bench honours this assumption: it changes the configuration only while busy is low, then waits two idle cycles before raising busy. Each transfer runs for a whole number of serial clock edges, and busy is dropped in the cycle after the last expected edge. This exercises both ending on a trailing edge and cutting off a non-idle phase.

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] prescale_code,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              late_capture,
  input  logic              busy,
  output logic              sclk,
  output logic              launch,
  output logic              sample
);

  localparam int LOW_W = CODE_W - 1;

  logic [LOW_W-1:0]  low_bits;
  logic [CODE_W-1:0] raw_div, div, hi_len, lo_len, half, cnt;
  logic              tgl, wrap, lead;

  assign low_bits = prescale_code[LOW_W-1:0];
  assign raw_div  = prescale_code[CODE_W-1] ? {low_bits, 1'b0} : {1'b0, low_bits};
  assign div      = (raw_div < CODE_W'(2)) ? CODE_W'(2) : raw_div;
  assign lo_len   = div >> 1;
  assign hi_len   = lo_len + {{(CODE_W-1){1'b0}}, div[0]};
  assign half     = tgl ? hi_len : lo_len;
  assign wrap     = (cnt == half - CODE_W'(1));
  assign lead     = ~tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl    <= 1'b0;
      cnt    <= '0;
      launch <= 1'b0;
      sample <= 1'b0;
    end else if (!busy) begin
      tgl    <= 1'b0;
      cnt    <= '0;
      launch <= 1'b0;
      sample <= 1'b0;
    end else if (wrap) begin
      tgl    <= ~tgl;
      cnt    <= '0;
      launch <= ~(lead ^ cpha);
      sample <= lead ? ~(cpha ^ late_capture) : (cpha ^ late_capture);
    end else begin
      cnt    <= cnt + CODE_W'(1);
      launch <= 1'b0;
      sample <= 1'b0;
    end
  end

  assign sclk = tgl ^ cpol;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic cpha,
  input logic late_capture,
  input logic busy,
  input logic sclk,
  input logic launch,
  input logic sample
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk == cpol) && !launch && !sample);

  assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch || sample) |-> (sclk != $past(sclk)));

  assert_launch_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ((sclk != cpol) == cpha));

  assert_launch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);

  assert_sample_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> ((sclk != cpol) == !(cpha ^ late_capture)));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
  .late_capture(late_capture), .busy(busy), .sclk(sclk),
  .launch(launch), .sample(sample)
);

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] prescale_code = 5'd4;
  logic       cpol = 1'b0, cpha = 1'b0, late_capture = 1'b0, busy = 1'b0;
  logic       sclk, launch, sample;

  always #10 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .prescale_code(prescale_code), .cpol(cpol),
    .cpha(cpha), .late_capture(late_capture), .busy(busy),
    .sclk(sclk), .launch(launch), .sample(sample)
  );

  typedef struct {
    int    cyc;
    logic  sc;
    logic  ln;
    logic  sm;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   watch = 0;
  bit   done = 0;
  logic prev_sclk = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #5;
    if (watch && ((sclk !== prev_sclk) || launch || sample)) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected activity at cycle %0d actual sclk/launch/sample %b/%b/%b expected none",
                 cyc, sclk, launch, sample);
      end else begin
        exp_t it;
        it = q.pop_front();
        if (it.cyc != cyc || it.sc !== sclk || it.ln !== launch || it.sm !== sample) begin
          errors++;
          $display("FAIL %s cycle/sclk/launch/sample actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                   it.req, cyc, sclk, launch, sample, it.cyc, it.sc, it.ln, it.sm);
        end
      end
    end
    prev_sclk = sclk;
  end

  task automatic check_idle(input string req);
    checks++;
    if (sclk !== cpol || launch !== 1'b0 || sample !== 1'b0) begin
      errors++;
      $display("FAIL %s idle sclk/launch/sample actual %b/%b/%b expected %b/0/0",
               req, sclk, launch, sample, cpol);
    end
  endtask

  task automatic run(input logic [4:0] code, input logic p, input logic h,
                     input logic lt, input int nedges, input string req);
    int d, lo, hi, t;
    @(negedge clk);
    watch = 0;
    prescale_code = code;
    cpol = p;
    cpha = h;
    late_capture = lt;
    repeat (2) @(negedge clk);
    d = (code >= 16) ? 2 * (code - 16) : int'(code);
    if (d < 2) d = 2;
    lo = d / 2;
    hi = d - lo;
    t = cyc;
    for (int j = 0; j < nedges; j++) begin
      exp_t it;
      bit leading;
      leading = (j % 2 == 0);
      t += leading ? lo : hi;
      it.cyc = t;
      it.sc  = leading ? ~p : p;
      it.ln  = leading ? h : ~h;
      it.sm  = leading ? ~(h ^ lt) : (h ^ lt);
      it.req = req;
      q.push_back(it);
    end
    if (nedges % 2 == 1) begin
      exp_t it;
      it.cyc = t + 1;
      it.sc  = p;
      it.ln  = 1'b0;
      it.sm  = 1'b0;
      it.req = "R9";
      q.push_back(it);
    end
    busy = 1'b1;
    watch = 1;
    while (cyc < t) @(negedge clk);
    busy = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s missing edges actual %0d pending expected 0", req, q.size());
      q.delete();
    end
    check_idle("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    prev_sclk = sclk;
    check_idle("R1");

    run(5'd4,  1'b0, 1'b0, 1'b0, 6, "R2/R6/R7");
    run(5'd15, 1'b0, 1'b1, 1'b0, 4, "R2/R7");
    run(5'd5,  1'b1, 1'b0, 1'b0, 6, "R5/R10");
    run(5'd7,  1'b0, 1'b1, 1'b0, 4, "R5");
    run(5'h18, 1'b0, 1'b0, 1'b0, 4, "R3");
    run(5'h1F, 1'b1, 1'b1, 1'b0, 4, "R3/R10");
    run(5'h13, 1'b0, 1'b0, 1'b0, 4, "R3");
    run(5'h10, 1'b0, 1'b0, 1'b0, 4, "R3");
    run(5'd0,  1'b0, 1'b0, 1'b0, 6, "R4");
    run(5'd1,  1'b1, 1'b1, 1'b0, 6, "R4");
    run(5'd2,  1'b0, 1'b0, 1'b1, 6, "R8");
    run(5'd2,  1'b1, 1'b1, 1'b1, 6, "R8");
    run(5'd3,  1'b0, 1'b0, 1'b1, 4, "R8/R5");
    run(5'd6,  1'b0, 1'b1, 1'b0, 3, "R9");
    run(5'd6,  1'b0, 1'b1, 1'b0, 4, "R9/R6");
    run(5'd9,  1'b1, 1'b0, 1'b0, 5, "R9/R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule